// File: doc/BRIEF.md
# Cluster Global Control Registers

This block is the memory-mapped control register file of a small multiprocessor cluster. Any processor can read or write it through a simple bus port. Each request carries an address, write data, a write strobe, a read strobe and the index of the requesting processor. The block holds three groups of state:

- its own relocatable base register;
- base/enable registers for an interrupt controller and a power controller, which drive an external address decoder;
- a small set of per-processor registers.

Each processor reaches the per-processor registers in two ways. A local window always maps to the requester's own copy. An indirect window maps to the copy named by the requester's peer-selector register. This lets one processor set up another processor's reset vector before releasing it.

The block exports three sets of outputs:

- the decoder base and enable values;
- a shifted copy of its own base, broadcast to every processor;
- one sign-extended 64-bit exception base per processor.

The processor count `NCPU` (1 to 8) is a parameter, as are the revision word and the reset value of the block base. Register offsets are word addresses on a 12-bit bus.

Top module: `cluster_ctrl_regs`

## Requirements
- R1: After reset the following values hold. The block base equals `BASE_RST & 0xFFFF0000`. The interrupt and power registers are 0, so both enables are low. Every peer selector is 0. Every stored vector base is 0xBFC00000, so every `exc_base` slice is 0xFFFFFFFF_BFC00000. `rdata` is 0.
- R2: `rdata` is registered. It reflects the register addressed while `rd_en` was high, one clock later. A read and a write in the same cycle return the value before the write. The write is visible to every later read.
- R3: The per-processor registers are reachable through two windows. The local window (0x100 count, 0x104 selector, 0x108 vector base) maps to the copy of processor `req_cpu`. The indirect window (0x200, 0x204, 0x208) maps to the copy of processor `sel[req_cpu]`.
- R4: A selector write stores `wdata[2:0]` only when that value is less than `NCPU`. Otherwise the selector keeps its old value.
- R5: A read of 0x100 or 0x200 returns `NCPU-1`.
- R6: The interrupt-controller register (0x010) and power-controller register (0x014) store `wdata & 0xFFFF0001`. This happens only while their presence input is high; otherwise the write is ignored. The base output is bits [31:16] with bits [15:0] zero, and the enable output is bit 0. Status reads return the presence input in bit 0: 0x018 for the interrupt controller, 0x01C for the power controller.
- R7: A write to 0x004 stores `wdata & 0xFFFF0000` as the block base. `core_base` outputs that value shifted right by 4.
- R8: A vector-base write stores `wdata & 0xFFFFF000`. The target processor's 64-bit `exc_base` slice is that value sign-extended from bit 31.
- R9: The following offsets read as fixed values: 0x000 reads 0, 0x008 reads `REV`, and 0x020 reads 0x00100000 (only the cache-bypass bit 20 set).
- R10: Reads of unmapped offsets return 0, and writes to them change nothing. Window accesses with `req_cpu >= NCPU` are treated the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_cpu | input | 3 | Index of requesting processor |
| addr | input | 12 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| ic_present | input | 1 | Interrupt controller attached |
| pc_present | input | 1 | Power controller attached |
| self_base | output | 32 | Block base address |
| core_base | output | 28 | Block base shifted right by 4, for all processors |
| ic_base | output | 32 | Interrupt controller decode base |
| ic_en | output | 1 | Interrupt controller decode enable |
| pc_base | output | 32 | Power controller decode base |
| pc_en | output | 1 | Power controller decode enable |
| exc_base | output | 64*NCPU | Per-processor exception base, slice i for processor i |

## Verification
The bench targets the following corner cases and the failure each would show:

- **Indirect-window aliasing.** A design that decoded the indirect window through the requester's own index would return or overwrite the wrong processor's vector base.
- **Selector bound.** It writes the selector at, above and just below `NCPU`. A missing or off-by-one bound leaves a selector pointing at a processor that does not exist.
- **Absent controllers.** It writes the power-controller register while that controller is absent. A missing presence gate would raise the decoder enable.
- **Sign extension and read ordering.** It writes vector bases with bit 31 both set and clear, which exposes zero-extension. It issues same-cycle read/write pairs, which expose a read path that forwards write data.

// File: rtl/cluster_ctrl_regs.sv
module cluster_ctrl_regs #(
  parameter int          NCPU     = 1,
  parameter logic [31:0] REV      = 32'h0000_0800,
  parameter logic [31:0] BASE_RST = 32'h1FBF_8000,
  parameter int          AW       = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         req_cpu,
  input  logic [AW-1:0]      addr,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic               ic_present,
  input  logic               pc_present,
  output logic [31:0]        self_base,
  output logic [27:0]        core_base,
  output logic [31:0]        ic_base,
  output logic               ic_en,
  output logic [31:0]        pc_base,
  output logic               pc_en,
  output logic [64*NCPU-1:0] exc_base
);
  localparam logic [AW-1:0] A_CFG    = AW'('h000);
  localparam logic [AW-1:0] A_SELF   = AW'('h004);
  localparam logic [AW-1:0] A_REV    = AW'('h008);
  localparam logic [AW-1:0] A_IC     = AW'('h010);
  localparam logic [AW-1:0] A_PC     = AW'('h014);
  localparam logic [AW-1:0] A_IC_ST  = AW'('h018);
  localparam logic [AW-1:0] A_PC_ST  = AW'('h01C);
  localparam logic [AW-1:0] A_CACHE  = AW'('h020);
  localparam logic [AW-1:0] A_L_CNT  = AW'('h100);
  localparam logic [AW-1:0] A_L_SEL  = AW'('h104);
  localparam logic [AW-1:0] A_L_VEC  = AW'('h108);
  localparam logic [AW-1:0] A_O_CNT  = AW'('h200);
  localparam logic [AW-1:0] A_O_SEL  = AW'('h204);
  localparam logic [AW-1:0] A_O_VEC  = AW'('h208);
  localparam logic [31:0]   CTL_MASK = 32'hFFFF_0001;
  localparam logic [19:0]   VEC_RST  = 20'hBFC00;
  localparam logic [31:0]   CNT_VAL  = 32'(NCPU - 1);

  logic [31:0] self_q, ic_q, pc_q, rd_mux;
  logic [2:0]  sel_q [8];
  logic [19:0] vec_q [8];
  logic        req_ok, sel_ok;
  logic [2:0]  tgt;

  assign req_ok = 32'(req_cpu) < NCPU;
  assign tgt    = sel_q[req_cpu];
  assign sel_ok = 32'(wdata[2:0]) < NCPU;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      self_q <= BASE_RST & 32'hFFFF_0000;
      ic_q   <= '0;
      pc_q   <= '0;
    end else if (wr_en) begin
      if (addr == A_SELF)               self_q <= wdata & 32'hFFFF_0000;
      if (addr == A_IC && ic_present)   ic_q   <= wdata & CTL_MASK;
      if (addr == A_PC && pc_present)   pc_q   <= wdata & CTL_MASK;
    end
  end

  for (genvar i = 0; i < 8; i++) begin : g_cpu
    if (i < NCPU) begin : g_live
      logic loc_hit, oth_hit;
      assign loc_hit = wr_en && req_ok && (req_cpu == 3'(i));
      assign oth_hit = wr_en && req_ok && (tgt == 3'(i));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sel_q[i] <= '0;
          vec_q[i] <= VEC_RST;
        end else begin
          if (sel_ok && ((loc_hit && addr == A_L_SEL) || (oth_hit && addr == A_O_SEL)))
            sel_q[i] <= wdata[2:0];
          if ((loc_hit && addr == A_L_VEC) || (oth_hit && addr == A_O_VEC))
            vec_q[i] <= wdata[31:12];
        end
      end
      assign exc_base[64*i +: 64] = {{32{vec_q[i][19]}}, vec_q[i], 12'h000};
    end else begin : g_none
      assign sel_q[i] = '0;
      assign vec_q[i] = '0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CFG:   rd_mux = '0;
      A_SELF:  rd_mux = self_q;
      A_REV:   rd_mux = REV;
      A_IC:    rd_mux = ic_q;
      A_PC:    rd_mux = pc_q;
      A_IC_ST: rd_mux = {31'b0, ic_present};
      A_PC_ST: rd_mux = {31'b0, pc_present};
      A_CACHE: rd_mux = 32'h0010_0000;
      A_L_CNT, A_O_CNT: rd_mux = req_ok ? CNT_VAL : '0;
      A_L_SEL: rd_mux = req_ok ? {29'b0, sel_q[req_cpu]} : '0;
      A_O_SEL: rd_mux = req_ok ? {29'b0, sel_q[tgt]} : '0;
      A_L_VEC: rd_mux = req_ok ? {vec_q[req_cpu], 12'h000} : '0;
      A_O_VEC: rd_mux = req_ok ? {vec_q[tgt], 12'h000} : '0;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign self_base = self_q;
  assign core_base = self_q[31:4];
  assign ic_base   = {ic_q[31:16], 16'h0000};
  assign ic_en     = ic_q[0];
  assign pc_base   = {pc_q[31:16], 16'h0000};
  assign pc_en     = pc_q[0];
endmodule

module cluster_ctrl_regs_chk #(
  parameter int          NCPU = 1,
  parameter logic [31:0] REV  = 32'h0000_0800,
  parameter int          AW   = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         req_cpu,
  input logic [AW-1:0]      addr,
  input logic               rd_en,
  input logic               wr_en,
  input logic [31:0]        rdata,
  input logic               ic_present,
  input logic               pc_present,
  input logic [31:0]        self_base,
  input logic [31:0]        ic_base,
  input logic               ic_en,
  input logic [31:0]        pc_base,
  input logic               pc_en,
  input logic [64*NCPU-1:0] exc_base
);
  a_r9_config_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == AW'('h000) |=> rdata == 32'h0);
  a_r9_revision: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == AW'('h008) |=> rdata == REV);
  a_r5_cpu_count: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == AW'('h100) || addr == AW'('h200)) && 32'(req_cpu) < NCPU
      |=> rdata == 32'(NCPU - 1));
  a_r6_ic_absent: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == AW'('h010) && !ic_present |=> $stable(ic_base) && $stable(ic_en));
  a_r6_pc_absent: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == AW'('h014) && !pc_present |=> $stable(pc_base) && $stable(pc_en));
  a_r6_ic_status: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == AW'('h018) |=> rdata == {31'b0, $past(ic_present)});
  a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == AW'('h300) |=> $stable(self_base) && $stable(exc_base)
      && $stable(ic_base) && $stable(pc_base));
  a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == AW'('h300) |=> rdata == 32'h0);
endmodule

bind cluster_ctrl_regs cluster_ctrl_regs_chk #(.NCPU(NCPU), .REV(REV), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_cpu(req_cpu), .addr(addr), .rd_en(rd_en),
  .wr_en(wr_en), .rdata(rdata), .ic_present(ic_present), .pc_present(pc_present),
  .self_base(self_base), .ic_base(ic_base), .ic_en(ic_en), .pc_base(pc_base),
  .pc_en(pc_en), .exc_base(exc_base)
);

// File: tb/cluster_ctrl_regs_test.sv
module cluster_ctrl_regs_test;
  localparam int          CLK_PERIOD = 10;
  localparam int          N          = 4;
  localparam logic [31:0] REVV       = 32'h0000_0800;
  localparam logic [31:0] BRST       = 32'h1FBF_8000;

  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0, ic_present = 1, pc_present = 0;
  logic [2:0] req_cpu = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0, rdata, self_base, ic_base, pc_base;
  logic [27:0] core_base;
  logic ic_en, pc_en;
  logic [64*N-1:0] exc_base;

  int checks = 0, errors = 0;
  logic [31:0] self_m, ic_m, pc_m;
  logic [31:0] vec_m [N];
  logic [2:0]  sel_m [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  cluster_ctrl_regs #(.NCPU(N), .REV(REVV), .BASE_RST(BRST)) uut (
    .clk(clk), .rst_n(rst_n), .req_cpu(req_cpu), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .ic_present(ic_present),
    .pc_present(pc_present), .self_base(self_base), .core_base(core_base),
    .ic_base(ic_base), .ic_en(ic_en), .pc_base(pc_base), .pc_en(pc_en),
    .exc_base(exc_base));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [2:0] c, logic [11:0] a);
    logic ok = 32'(c) < N;
    logic [2:0] t = ok ? sel_m[c[1:0]] : 3'd0;
    case (a)
      12'h000: return 0;
      12'h004: return self_m;
      12'h008: return REVV;
      12'h010: return ic_m;
      12'h014: return pc_m;
      12'h018: return {31'b0, ic_present};
      12'h01C: return {31'b0, pc_present};
      12'h020: return 32'h0010_0000;
      12'h100, 12'h200: return ok ? 32'(N - 1) : 0;
      12'h104: return ok ? {29'b0, sel_m[c[1:0]]} : 0;
      12'h204: return ok ? {29'b0, sel_m[t[1:0]]} : 0;
      12'h108: return ok ? vec_m[c[1:0]] : 0;
      12'h208: return ok ? vec_m[t[1:0]] : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(logic [11:0] a);
    case (a)
      12'h004: return "R7";
      12'h010, 12'h014, 12'h018, 12'h01C: return "R6";
      12'h000, 12'h008, 12'h020: return "R9";
      12'h100, 12'h200: return "R5";
      12'h104, 12'h204: return "R4";
      12'h108, 12'h208: return "R3";
      default: return "R10";
    endcase
  endfunction

  task automatic model_write(logic [2:0] c, logic [11:0] a, logic [31:0] d);
    logic ok = 32'(c) < N;
    logic [2:0] t = ok ? sel_m[c[1:0]] : 3'd0;
    case (a)
      12'h004: self_m = d & 32'hFFFF_0000;
      12'h010: if (ic_present) ic_m = d & 32'hFFFF_0001;
      12'h014: if (pc_present) pc_m = d & 32'hFFFF_0001;
      12'h104: if (ok && 32'(d[2:0]) < N) sel_m[c[1:0]] = d[2:0];
      12'h204: if (ok && 32'(d[2:0]) < N) sel_m[t[1:0]] = d[2:0];
      12'h108: if (ok) vec_m[c[1:0]] = d & 32'hFFFF_F000;
      12'h208: if (ok) vec_m[t[1:0]] = d & 32'hFFFF_F000;
      default: ;
    endcase
  endtask

  task automatic check_outputs(string tag);
    check({tag, " R7 self_base"}, 64'(self_base), 64'(self_m));
    check({tag, " R7 core_base"}, 64'(core_base), 64'(self_m >> 4));
    check({tag, " R6 ic_base"}, {32'b0, ic_base}, {32'b0, ic_m[31:16], 16'h0});
    check({tag, " R6 ic_en"}, 64'(ic_en), 64'(ic_m[0]));
    check({tag, " R6 pc_base"}, {32'b0, pc_base}, {32'b0, pc_m[31:16], 16'h0});
    check({tag, " R6 pc_en"}, 64'(pc_en), 64'(pc_m[0]));
    for (int i = 0; i < N; i++)
      check({tag, " R8 exc_base"}, exc_base[64*i +: 64], {{32{vec_m[i][31]}}, vec_m[i]});
  endtask

  // Called at a falling edge; returns at the next falling edge, with results checked.
  task automatic op(logic [2:0] c, logic [11:0] a, logic rd, logic wr, logic [31:0] d, string tag);
    logic [31:0] exp;
    req_cpu = c; addr = a; rd_en = rd; wr_en = wr; wdata = d;
    exp = exp_read(c, a);
    if (wr) model_write(c, a, d);
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    if (rd) check({tag, " R2 rdata"}, 64'(rdata), 64'(exp));
    check_outputs(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    self_m = BRST & 32'hFFFF_0000; ic_m = 0; pc_m = 0;
    for (int i = 0; i < N; i++) begin sel_m[i] = 0; vec_m[i] = 32'hBFC0_0000; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 rdata", 64'(rdata), 0);
    check_outputs("R1 reset");
    check("R1 exc_base0", exc_base[63:0], 64'hFFFF_FFFF_BFC0_0000);
    op(0, 12'h104, 1, 0, 0, "R1 sel");
    // fixed reads
    op(1, 12'h000, 1, 0, 0, "R9 cfg");
    op(1, 12'h008, 1, 0, 0, "R9 rev");
    op(1, 12'h020, 1, 0, 0, "R9 cache");
    op(2, 12'h100, 1, 0, 0, "R5 local cnt");
    op(3, 12'h200, 1, 0, 0, "R5 other cnt");
    // controllers
    op(0, 12'h010, 0, 1, 32'hABCD_FFFF, "R6 ic write");
    op(0, 12'h014, 0, 1, 32'h1234_5671, "R6 pc absent");
    op(0, 12'h018, 1, 0, 0, "R6 ic status");
    op(0, 12'h01C, 1, 0, 0, "R6 pc status");
    op(0, 12'h010, 1, 0, 0, "R6 ic read");
    // self base
    op(2, 12'h004, 0, 1, 32'h2345_6789, "R7 self");
    op(2, 12'h004, 1, 0, 0, "R7 self read");
    // selector bounds and indirect window
    op(0, 12'h104, 0, 1, 32'h0000_0003, "R4 sel ok");
    op(0, 12'h104, 1, 0, 0, "R4 sel read");
    op(0, 12'h104, 0, 1, 32'h0000_0004, "R4 sel at bound");
    op(0, 12'h104, 1, 0, 0, "R4 sel kept");
    op(0, 12'h204, 0, 1, 32'hFFFF_FFFF, "R4 sel 7 other");
    op(3, 12'h104, 1, 0, 0, "R4 peer kept");
    op(0, 12'h208, 0, 1, 32'h8765_4ABC, "R3 other vec");
    op(3, 12'h108, 1, 0, 0, "R3 peer local view");
    op(0, 12'h108, 1, 0, 0, "R3 own untouched");
    op(0, 12'h208, 1, 0, 0, "R3 other read");
    op(1, 12'h108, 0, 1, 32'h1234_5FFF, "R8 positive vec");
    // same-cycle read and write
    op(1, 12'h108, 1, 1, 32'hC000_0000, "R2 rw same");
    op(1, 12'h108, 1, 0, 0, "R2 after write");
    // unmapped / invalid requester
    op(0, 12'h300, 1, 1, 32'hFFFF_FFFF, "R10 unmapped");
    op(5, 12'h108, 1, 1, 32'h0, "R10 bad cpu");
    op(5, 12'h104, 1, 0, 0, "R10 bad cpu read");
    pc_present = 1;
    op(0, 12'h014, 0, 1, 32'h5555_AAAB, "R6 pc present");
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [11:0] alist [15] = '{12'h000, 12'h004, 12'h008, 12'h010, 12'h014, 12'h018,
                                  12'h01C, 12'h020, 12'h100, 12'h104, 12'h108,
                                  12'h200, 12'h204, 12'h208, 12'h300};
      logic [11:0] a = alist[$urandom_range(0, 14)];
      logic [2:0]  c = ($urandom_range(0, 9) == 0) ? 3'd6 : 3'($urandom_range(0, N-1));
      logic [31:0] d = (a == 12'h104 || a == 12'h204) ? 32'($urandom_range(0, 7)) : $urandom;
      logic wr = $urandom_range(0, 1) == 1;
      logic rd = !wr || ($urandom_range(0, 3) == 0);
      if (n == 300) ic_present = 0;
      op(c, a, rd, wr, d, tag_of(a));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule